// File: doc/BRIEF.md
# Streaming Region-Averaging Intensity Extractor

This block turns a raster stream of greyscale pixels into one mean intensity per stimulation site, without storing the frame. Each pixel arrives with its x/y coordinate. Every site owns a square sampling region whose edge is a power of two from 1 to 32 pixels. Regions sit on a grid: the pitch is the region edge plus a gap that can be set in steps of one pixel, and the grid starts at a programmable origin. A per-site lookup table gives each site its grid column and row, so a rotated or transposed electrode layout is a matter of rewriting table entries.

Each site has its own running sum and pixel count. The start-of-frame pixel clears them. After the end-of-frame pixel is accepted, a sequencer works through the sites one at a time. A site whose region was fully covered is averaged with a right shift. A site clipped by the image edge goes through a serial restoring divider. Results land in the inactive half of a two-bank table, and the banks swap once every site is written. A consumer reads any site on request and always gets a value from the last completed frame.

Top module: `region_avg`

## Requirements
- R1: After reset `pix_ready` is 1 and a read of any site returns 0.
- R2: With k = `cfg_size_log2` (0..5, larger values act as 5) and spacing s, the region of a site with grid cell (c, r) covers x in [ox + c·(2^k+s), ox + c·(2^k+s) + 2^k) and y in [oy + r·(2^k+s), oy + r·(2^k+s) + 2^k). Its result is floor(sum / count) over the accepted pixels of the frame that fall inside it.
- R3: A region that is only partly inside the image averages only the pixels actually received. A region that receives no pixels yields 0.
- R4: Out of reset, site i sits in grid cell (i mod GRID_COLS, i div GRID_COLS).
- R5: A cycle with `map_wr_en` high sets site `map_wr_site` to cell (`map_wr_col`, `map_wr_row`) for every pixel accepted afterwards.
- R6: Size, spacing and origin are sampled with the start-of-frame pixel. Changes to them later in the frame have no effect on that frame's results.
- R7: In the cycle after an end-of-frame pixel is accepted, `pix_ready` is 0. It stays 0 until every site's result is stored, which takes at most NUM_SITES·(ACC_W+3) cycles.
- R8: `rd_en` in one cycle gives `rd_valid` high in the next cycle, carrying the site's value. Until the table swap, reads return the previous completed frame, including reads made during the unload. A site index of NUM_SITES or more reads 0.
- R9: The start-of-frame pixel discards all sums from earlier frames.
- R10: A pixel is taken only on a cycle where both `pix_valid` and `pix_ready` are high. Idle cycles between pixels do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Block can take a pixel (low while unloading) |
| pix_data | input | PIX_W | Greyscale value |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eof | input | 1 | Last pixel of a frame |
| cfg_size_log2 | input | 3 | Region edge exponent |
| cfg_spacing | input | SP_W | Gap between regions in pixels |
| cfg_org_x | input | COORD_W | Grid origin column |
| cfg_org_y | input | COORD_W | Grid origin row |
| map_wr_en | input | 1 | Write one site's grid cell |
| map_wr_site | input | SITE_W | Site to remap |
| map_wr_col | input | COL_W | New grid column |
| map_wr_row | input | ROW_W | New grid row |
| rd_en | input | 1 | Read request |
| rd_site | input | SITE_W | Site to read |
| rd_valid | output | 1 | Read data present |
| rd_data | output | PIX_W | Averaged intensity |

The stream follows valid/ready rules. The source holds a pixel and its tags stable until `pix_ready` takes it. The block only stalls the source during the unload after end of frame. Reads have no back-pressure: the consumer starts every transfer.

## Verification
The bench builds the block with six sites on a three-column grid and 8-bit coordinates, streaming a 40×24 image. This small image lets the grid origin and spacing push regions past the right and bottom edges, and lets a 32-pixel region be clipped. Both the shift path and the divider path are reached, as are regions that receive no pixels at all. Six sites keep the unload short enough that a read issued straight after end of frame still lands before the table swap.

// File: rtl/region_avg_pkg.sv
package region_avg_pkg;
  localparam int MAX_LOG2 = 5;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PICK,
    ST_DIV
  } ravg_state_e;

  function automatic logic [2:0] clamp_log2(input logic [2:0] v);
    return (v > 3'(MAX_LOG2)) ? 3'(MAX_LOG2) : v;
  endfunction
endpackage

// File: rtl/region_avg_map.sv
module region_avg_map #(
  parameter int NUM_SITES = 98,
  parameter int GRID_COLS = 14,
  parameter int COL_W     = 4,
  parameter int ROW_W     = 4,
  parameter int SITE_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SITE_W-1:0] wr_site,
  input  logic [COL_W-1:0] wr_col,
  input  logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] col_o [NUM_SITES],
  output logic [ROW_W-1:0] row_o [NUM_SITES]
);
  for (genvar i = 0; i < NUM_SITES; i++) begin : g_entry
    localparam int DEF_COL = i % GRID_COLS;
    localparam int DEF_ROW = i / GRID_COLS;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        col_o[i] <= COL_W'(DEF_COL);
        row_o[i] <= ROW_W'(DEF_ROW);
      end else if (wr_en && (32'(wr_site) == i)) begin
        col_o[i] <= wr_col;
        row_o[i] <= wr_row;
      end
    end
  end
endmodule

// File: rtl/region_avg_lane.sv
module region_avg_lane #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 10,
  parameter int SP_W    = 6,
  parameter int COL_W   = 4,
  parameter int ROW_W   = 4,
  parameter int ACC_W   = 18,
  parameter int CNT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               clear,
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic [PIX_W-1:0]   pd,
  input  logic [2:0]         k,
  input  logic [SP_W-1:0]    spacing,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic [COL_W-1:0]   col,
  input  logic [ROW_W-1:0]   row,
  output logic [ACC_W-1:0]   sum_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int XW = COORD_W + COL_W + ROW_W + SP_W + 2;

  logic [XW-1:0] size, pitch, x0, y0, xe, ye;
  logic          hit;

  always_comb begin
    size  = XW'(1) << k;
    pitch = size + XW'(spacing);
    x0    = XW'(org_x) + XW'(col) * pitch;
    y0    = XW'(org_y) + XW'(row) * pitch;
    xe    = XW'(px);
    ye    = XW'(py);
    hit   = (xe >= x0) && (xe < x0 + size) && (ye >= y0) && (ye < y0 + size);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_o <= '0;
      cnt_o <= '0;
    end else if (take) begin
      if (clear) begin
        sum_o <= hit ? ACC_W'(pd) : '0;
        cnt_o <= hit ? CNT_W'(1) : '0;
      end else if (hit) begin
        sum_o <= sum_o + ACC_W'(pd);
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/region_avg_div.sv
module region_avg_div #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int RW  = DEN_W + 2;
  localparam int ITW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [ITW-1:0]   iter;
  logic             busy;
  logic [RW-1:0]    shifted, diff;

  always_comb begin
    shifted = {1'b0, rem, quo[NUM_W-1]};
    diff    = shifted - RW'(den_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      iter  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        den_q <= den;
        quo   <= num;
        iter  <= ITW'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!diff[RW-1]) begin
          rem <= diff[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= shifted[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        iter <= iter - ITW'(1);
        if (iter == ITW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/region_avg.sv
module region_avg
  import region_avg_pkg::*;
#(
  parameter int NUM_SITES = 98,
  parameter int GRID_COLS = 14,
  parameter int PIX_W     = 8,
  parameter int COORD_W   = 10,
  parameter int SP_W      = 6,
  parameter int COL_W     = 4,
  parameter int ROW_W     = 4,
  parameter int ACC_W     = 18,
  parameter int SITE_W    = (NUM_SITES > 1) ? $clog2(NUM_SITES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [PIX_W-1:0]   pix_data,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               pix_sof,
  input  logic               pix_eof,
  input  logic [2:0]         cfg_size_log2,
  input  logic [SP_W-1:0]    cfg_spacing,
  input  logic [COORD_W-1:0] cfg_org_x,
  input  logic [COORD_W-1:0] cfg_org_y,
  input  logic               map_wr_en,
  input  logic [SITE_W-1:0]  map_wr_site,
  input  logic [COL_W-1:0]   map_wr_col,
  input  logic [ROW_W-1:0]   map_wr_row,
  input  logic               rd_en,
  input  logic [SITE_W-1:0]  rd_site,
  output logic               rd_valid,
  output logic [PIX_W-1:0]   rd_data
);
  localparam int CNT_W = 2 * MAX_LOG2 + 1;

  ravg_state_e         state;
  logic [SITE_W-1:0]   idx;
  logic                bank;
  logic                take, sof_take;

  // frame-start configuration shadow
  logic [2:0]          k_sh, k_eff;
  logic [SP_W-1:0]     sp_sh, sp_eff;
  logic [COORD_W-1:0]  ox_sh, oy_sh, ox_eff, oy_eff;

  logic [COL_W-1:0]    map_col [NUM_SITES];
  logic [ROW_W-1:0]    map_row [NUM_SITES];
  logic [ACC_W-1:0]    sum_a   [NUM_SITES];
  logic [CNT_W-1:0]    cnt_a   [NUM_SITES];
  logic [PIX_W-1:0]    tbl     [2][NUM_SITES];

  assign pix_ready = (state == ST_RUN);
  assign take      = pix_valid && pix_ready;
  assign sof_take  = take && pix_sof;

  always_comb begin
    k_eff  = sof_take ? clamp_log2(cfg_size_log2) : k_sh;
    sp_eff = sof_take ? cfg_spacing : sp_sh;
    ox_eff = sof_take ? cfg_org_x : ox_sh;
    oy_eff = sof_take ? cfg_org_y : oy_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_sh  <= '0;
      sp_sh <= '0;
      ox_sh <= '0;
      oy_sh <= '0;
    end else if (sof_take) begin
      k_sh  <= k_eff;
      sp_sh <= sp_eff;
      ox_sh <= ox_eff;
      oy_sh <= oy_eff;
    end
  end

  region_avg_map #(
    .NUM_SITES(NUM_SITES), .GRID_COLS(GRID_COLS),
    .COL_W(COL_W), .ROW_W(ROW_W), .SITE_W(SITE_W)
  ) map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_wr_en), .wr_site(map_wr_site),
    .wr_col(map_wr_col), .wr_row(map_wr_row),
    .col_o(map_col), .row_o(map_row)
  );

  for (genvar i = 0; i < NUM_SITES; i++) begin : g_lane
    region_avg_lane #(
      .PIX_W(PIX_W), .COORD_W(COORD_W), .SP_W(SP_W),
      .COL_W(COL_W), .ROW_W(ROW_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
    ) lane_i (
      .clk(clk), .rst_n(rst_n),
      .take(take), .clear(pix_sof),
      .px(pix_x), .py(pix_y), .pd(pix_data),
      .k(k_eff), .spacing(sp_eff), .org_x(ox_eff), .org_y(oy_eff),
      .col(map_col[i]), .row(map_row[i]),
      .sum_o(sum_a[i]), .cnt_o(cnt_a[i])
    );
  end

  // unload sequencer
  logic [ACC_W-1:0] sum_sel, sum_shr;
  logic [CNT_W-1:0] cnt_sel, full_cnt;
  logic             div_start, div_done, wr_en, last;
  logic [PIX_W-1:0] wr_val;
  logic [ACC_W-1:0] div_q;

  always_comb begin
    sum_sel   = sum_a[idx];
    cnt_sel   = cnt_a[idx];
    full_cnt  = CNT_W'(1) << {k_sh, 1'b0};
    sum_shr   = sum_sel >> {k_sh, 1'b0};
    last      = (32'(idx) == NUM_SITES - 1);
    div_start = 1'b0;
    wr_en     = 1'b0;
    wr_val    = '0;
    case (state)
      ST_PICK: begin
        if (cnt_sel == '0) begin
          wr_en = 1'b1;
        end else if (cnt_sel == full_cnt) begin
          wr_en  = 1'b1;
          wr_val = sum_shr[PIX_W-1:0];
        end else begin
          div_start = 1'b1;
        end
      end
      ST_DIV: begin
        if (div_done) begin
          wr_en  = 1'b1;
          wr_val = div_q[PIX_W-1:0];
        end
      end
      default: ;
    endcase
  end

  region_avg_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) div_i (
    .clk(clk), .rst_n(rst_n),
    .start(div_start), .num(sum_sel), .den(cnt_sel),
    .done(div_done), .quo(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RUN;
      idx   <= '0;
      bank  <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (take && pix_eof) begin
            state <= ST_PICK;
            idx   <= '0;
          end
        end
        ST_PICK, ST_DIV: begin
          if (div_start) begin
            state <= ST_DIV;
          end else if (wr_en) begin
            if (last) begin
              state <= ST_RUN;
              bank  <= ~bank;
            end else begin
              state <= ST_PICK;
              idx   <= idx + SITE_W'(1);
            end
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NUM_SITES; s++)
          tbl[b][s] <= '0;
    end else if (wr_en) begin
      tbl[~bank][idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= (32'(rd_site) < NUM_SITES) ? tbl[bank][rd_site] : '0;
    end
  end
endmodule

// File: rtl/region_avg_chk.sv
module region_avg_chk #(
  parameter int NUM_SITES = 98,
  parameter int ACC_W     = 18,
  parameter int PIX_W     = 8,
  parameter int SITE_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              pix_sof,
  input logic              pix_eof,
  input logic              rd_en,
  input logic [SITE_W-1:0] rd_site,
  input logic              rd_valid,
  input logic [PIX_W-1:0]  rd_data,
  input logic [2:0]        k_sh
);
  localparam int LIMIT = NUM_SITES * (ACC_W + 3);

  int stall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) stall_cnt <= 0;
    else if (pix_ready) stall_cnt <= 0;
    else stall_cnt <= stall_cnt + 1;
  end

  AST_STALL_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_eof) |=> !pix_ready); // R7

  AST_UNLOAD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ready |-> (stall_cnt <= LIMIT)); // R7

  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R8

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R8

  AST_RD_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(rd_site) >= NUM_SITES)) |=> (rd_data == '0)); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready && pix_sof) |=> $stable(k_sh)); // R6
endmodule

bind region_avg region_avg_chk #(
  .NUM_SITES(NUM_SITES), .ACC_W(ACC_W), .PIX_W(PIX_W), .SITE_W(SITE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_sof(pix_sof), .pix_eof(pix_eof),
  .rd_en(rd_en), .rd_site(rd_site),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .k_sh(k_sh)
);

// File: tb/region_avg_tb_top.sv
module region_avg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 6;
  localparam int GC    = 3;
  localparam int PW    = 8;
  localparam int CW    = 8;
  localparam int SPW   = 6;
  localparam int CLW   = 4;
  localparam int RWW   = 4;
  localparam int AW    = 18;
  localparam int SW    = 3;
  localparam int IMG_W = 40;
  localparam int IMG_H = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, pix_ready, pix_sof = 1'b0, pix_eof = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic [CW-1:0] pix_x = '0, pix_y = '0;
  logic [2:0] cfg_size_log2 = '0;
  logic [SPW-1:0] cfg_spacing = '0;
  logic [CW-1:0] cfg_org_x = '0, cfg_org_y = '0;
  logic map_wr_en = 1'b0;
  logic [SW-1:0] map_wr_site = '0;
  logic [CLW-1:0] map_wr_col = '0;
  logic [RWW-1:0] map_wr_row = '0;
  logic rd_en = 1'b0, rd_valid;
  logic [SW-1:0] rd_site = '0;
  logic [PW-1:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  region_avg #(
    .NUM_SITES(NS), .GRID_COLS(GC), .PIX_W(PW), .COORD_W(CW), .SP_W(SPW),
    .COL_W(CLW), .ROW_W(RWW), .ACC_W(AW), .SITE_W(SW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_x(pix_x), .pix_y(pix_y), .pix_sof(pix_sof), .pix_eof(pix_eof),
    .cfg_size_log2(cfg_size_log2), .cfg_spacing(cfg_spacing),
    .cfg_org_x(cfg_org_x), .cfg_org_y(cfg_org_y),
    .map_wr_en(map_wr_en), .map_wr_site(map_wr_site),
    .map_wr_col(map_wr_col), .map_wr_row(map_wr_row),
    .rd_en(rd_en), .rd_site(rd_site), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int img [IMG_H][IMG_W];
  int bcol [NS], brow [NS], prev [NS], expv [NS];
  int fk, fsp, fox, foy;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_avg(int s);
    int sz, x0, y0, sum, n;
    sz = 1 << fk; sum = 0; n = 0;
    x0 = fox + bcol[s] * (sz + fsp);
    y0 = foy + brow[s] * (sz + fsp);
    for (int y = y0; y < y0 + sz; y++)
      for (int x = x0; x < x0 + sz; x++)
        if (x < IMG_W && y < IMG_H) begin
          sum += img[y][x]; n++;
        end
    return (n == 0) ? 0 : sum / n;
  endfunction

  task automatic read_site(int s, output int v);
    rd_en = 1'b1; rd_site = SW'(s);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 rd_valid", int'(rd_valid), 1);
    v = int'(rd_data);
  endtask

  task automatic send_pix(int x, int y, bit sof, bit eof);
    if ($urandom % 4 == 0) begin
      pix_valid = 1'b0;
      @(negedge clk);
    end
    pix_valid = 1'b1;
    pix_x = CW'(x); pix_y = CW'(y); pix_data = PW'(img[y][x]);
    pix_sof = sof; pix_eof = eof;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic map_write(int s, int c, int r);
    map_wr_en = 1'b1; map_wr_site = SW'(s);
    map_wr_col = CLW'(c); map_wr_row = RWW'(r);
    @(negedge clk);
    map_wr_en = 1'b0;
    bcol[s] = c; brow[s] = r;
  endtask

  task automatic run_frame(int k, int sp, int ox, int oy, bit midchg, string tag);
    int v;
    fk = k; fsp = sp; fox = ox; foy = oy;
    cfg_size_log2 = 3'(k); cfg_spacing = SPW'(sp);
    cfg_org_x = CW'(ox); cfg_org_y = CW'(oy);
    for (int y = 0; y < IMG_H; y++)
      for (int x = 0; x < IMG_W; x++)
        img[y][x] = $urandom % 256;
    for (int y = 0; y < IMG_H; y++)
      for (int x = 0; x < IMG_W; x++) begin
        if (midchg && y == 1 && x == 0) begin
          cfg_size_log2 = 3'((k + 1) % 6);
          cfg_spacing   = SPW'(sp + 3);
          cfg_org_x     = CW'(ox + 2);
          cfg_org_y     = CW'(oy + 1);
        end
        send_pix(x, y, (x == 0 && y == 0), (x == IMG_W - 1 && y == IMG_H - 1));
      end
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    chk("R7 ready low after eof", int'(pix_ready), 0);
    read_site(0, v);
    chk("R8 old frame during unload", v, prev[0]);
    while (!pix_ready) @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      expv[s] = exp_avg(s);
      read_site(s, v);
      chk(tag, v, expv[s]);
      prev[s] = expv[s];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++) begin
      bcol[s] = s % GC; brow[s] = s / GC; prev[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", int'(pix_ready), 1);
    for (int s = 0; s < NS; s++) begin
      read_site(s, v);
      chk("R1 zero after reset", v, 0);
    end
    read_site(7, v);
    chk("R8 out-of-range site", v, 0);
    // R2 R4 full regions, shift path, default map
    run_frame(0, 3, 2, 1, 1'b0, "R4 default map 1x1");
    run_frame(2, 1, 5, 4, 1'b0, "R2 4x4 regions");
    // R3 partial and empty regions
    run_frame(3, 5, 20, 10, 1'b0, "R3 clipped/empty 8x8");
    run_frame(5, 0, 0, 0, 1'b0, "R3 clipped 32x32");
    // R5 remap: swap sites 0 and 4
    map_write(0, 1, 1);
    map_write(4, 0, 0);
    run_frame(1, 2, 3, 2, 1'b0, "R5 remapped sites");
    // R6 mid-frame configuration change ignored
    run_frame(2, 2, 1, 1, 1'b1, "R6 cfg held from sof");
    // R9 R10 random frames with idle gaps
    for (int f = 0; f < 4; f++)
      run_frame($urandom % 6, $urandom % 8, $urandom % 16, $urandom % 8, 1'b0,
                "R9 R10 random frame");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule